// File: doc/BRIEF.md
# Two-Pass Scan Debug Register Port

This block lets an external debug host reach a small set of 32-bit control and status registers through the data-register path of an IEEE 1149.1 test access port. The TAP state machine and its instruction decode sit outside. The block receives the capture-DR, shift-DR and update-DR state decodes, a flag that says the debug-enable instruction is loaded, TDI and TCK. It drives TDO. Every access takes two DR scans. The first scan selects a register and a direction. The second scan moves the data.

A two-state controller tracks which scan comes next. In state PH_SELECT, an 8-bit scan `{index[6:0], dir}` is shifted in LSB first, so the direction bit goes in first. At update-DR the controller latches the index and direction and takes the transition SELECT_TO_DATA. In state PH_DATA, capture-DR loads the chosen register into a 32-bit shift register, and that value is shifted out LSB first. At update-DR the controller takes the transition DATA_TO_SELECT. If the direction is write, the shifted-in word is stored in the register at that moment. The transition ANY_TO_SELECT is taken whenever the debug-enable instruction is absent or the debug reset is active.

The block also produces an active-low debug reset. This reset clears the port and every register in the bank. It works like a TRST line for the rest of the debug logic.

Top module: `dbg_scan_port`

## Requirements
- R1: `dbg_rst_n` is low whenever `por_n` is low, `tst_comp_en` is low, or `dbg_lock` is high. Otherwise it is high.
- R2: While `dbg_rst_n` is low, every bank register is cleared to zero and the controller is in PH_SELECT. After reset is released, a read of any register returns 0.
- R3: The select scan is 8 bits, shifted LSB first. Bit 0 is the direction (1 = write, 0 = read) and bits 7:1 are the register index. During this scan TDO shifts out zeros.
- R4: An update-DR in PH_SELECT latches the index and direction and moves the controller to PH_DATA. An update-DR in PH_DATA returns it to PH_SELECT.
- R5: On a write access, the 32-bit data scan shifts out the register's previous contents, LSB first. The register takes the shifted-in value at the update-DR of that scan.
- R6: On a read access, the data scan shifts out the register's contents, LSB first. The bits shifted in during that scan leave every register unchanged.
- R7: While `instr_dbg` is low, capture, shift and update decodes have no effect on any register, TDO is 0, and the controller returns to PH_SELECT.
- R8: Indices at or above NUM_REGS (default 4) read as zero, and writes to them change no register.
- R9: TDO is 0 whenever `shf_dr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low |
| tst_comp_en | input | 1 | Test compliance enable; low holds debug logic in reset |
| dbg_lock | input | 1 | Secured mode; high holds debug logic in reset |
| instr_dbg | input | 1 | Debug-enable instruction is loaded in the TAP |
| cap_dr | input | 1 | TAP is in capture-DR |
| shf_dr | input | 1 | TAP is in shift-DR |
| upd_dr | input | 1 | TAP is in update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dbg_rst_n | output | 1 | Shared debug reset, active low |

## Verification
The hardest case to reach is losing the debug-enable instruction between the two passes of an access. If the controller then stayed in PH_DATA, the next select scan would be taken as a data scan: it would capture and overwrite a register without any visible error. The stimulus completes a select pass, drops `instr_dbg` while also pulsing shift and update, then restores the instruction and issues a new select-plus-read. The target register holds a pattern with a non-zero low byte, so a stale phase shows up both in the select-pass TDO bits and in the value read back. Random accesses over indices 0 to 7 mix mapped and unmapped targets, checking both the old data returned by writes and that unmapped writes are discarded.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic {
        PH_SELECT = 1'b0,
        PH_DATA   = 1'b1
    } phase_e;
endpackage

// File: rtl/dsp_reset_gen.sv
module dsp_reset_gen (
    input  logic por_n,
    input  logic tst_comp_en,
    input  logic dbg_lock,
    output logic dbg_rst_n
);
    // any one source holds the whole debug domain in reset
    assign dbg_rst_n = por_n & tst_comp_en & ~dbg_lock;
endmodule

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
    import dsp_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int SEL_W = IDX_W + 1
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             instr_dbg,
    input  logic             upd_dr,
    input  logic [SEL_W-1:0] sel_bits,
    output phase_e           phase_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             dir_q,
    output logic             wr_en
);
    phase_e phase_d;

    // state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_SELECT;
        else        phase_q <= phase_d;
    end

    // transitions
    always_comb begin
        phase_d = phase_q;
        if (!instr_dbg) begin
            phase_d = PH_SELECT;                 // ANY_TO_SELECT
        end else if (upd_dr) begin
            unique case (phase_q)
                PH_SELECT: phase_d = PH_DATA;    // SELECT_TO_DATA
                PH_DATA:   phase_d = PH_SELECT;  // DATA_TO_SELECT
                default:   phase_d = PH_SELECT;
            endcase
        end
    end

    // select latch: bit 0 is direction, upper bits the index
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            dir_q <= 1'b0;
        end else if (instr_dbg && upd_dr && phase_q == PH_SELECT) begin
            idx_q <= sel_bits[SEL_W-1:1];
            dir_q <= sel_bits[0];
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (phase_q)
            PH_SELECT: wr_en = 1'b0;
            PH_DATA:   wr_en = instr_dbg & upd_dr & dir_q;
            default:   wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
    import dsp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              en,
    input  phase_e            phase,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] sr_q,
    output logic              tdo
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (en) begin
            if (cap_dr) begin
                sr_q <= (phase == PH_DATA) ? cap_val : '0;
            end else if (shf_dr) begin
                if (phase == PH_DATA)
                    sr_q <= {tdi, sr_q[DATA_W-1:1]};
                else
                    sr_q[SEL_W-1:0] <= {tdi, sr_q[SEL_W-1:1]};
            end
        end
    end

    assign tdo = rst_n & en & shf_dr & sr_q[0];
endmodule

// File: rtl/dsp_regbank.sv
module dsp_regbank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 7
) (
    input  logic                       tck,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))
                regs_q[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // unmapped indices fall through to zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rdata = regs_q[i];
    end
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
    import dsp_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 7
) (
    input  logic tck,
    input  logic por_n,
    input  logic tst_comp_en,
    input  logic dbg_lock,
    input  logic instr_dbg,
    input  logic cap_dr,
    input  logic shf_dr,
    input  logic upd_dr,
    input  logic tdi,
    output logic tdo,
    output logic dbg_rst_n
);
    localparam int SEL_W = IDX_W + 1;

    phase_e                     phase_q;
    logic [IDX_W-1:0]           idx_q;
    logic                       dir_q;
    logic                       wr_en;
    logic [DATA_W-1:0]          sr_q;
    logic [DATA_W-1:0]          rdata;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    dsp_reset_gen u_rst (
        .por_n       (por_n),
        .tst_comp_en (tst_comp_en),
        .dbg_lock    (dbg_lock),
        .dbg_rst_n   (dbg_rst_n)
    );

    dsp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .tck       (tck),
        .rst_n     (dbg_rst_n),
        .instr_dbg (instr_dbg),
        .upd_dr    (upd_dr),
        .sel_bits  (sr_q[SEL_W-1:0]),
        .phase_q   (phase_q),
        .idx_q     (idx_q),
        .dir_q     (dir_q),
        .wr_en     (wr_en)
    );

    dsp_shifter #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_shf (
        .tck     (tck),
        .rst_n   (dbg_rst_n),
        .en      (instr_dbg),
        .phase   (phase_q),
        .cap_dr  (cap_dr),
        .shf_dr  (shf_dr),
        .tdi     (tdi),
        .cap_val (rdata),
        .sr_q    (sr_q),
        .tdo     (tdo)
    );

    dsp_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .tck       (tck),
        .rst_n     (dbg_rst_n),
        .wr_en     (wr_en),
        .idx       (idx_q),
        .wdata     (sr_q),
        .rdata     (rdata),
        .regs_flat (regs_flat)
    );
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker
    import dsp_pkg::*;
#(
    parameter int W = 128
) (
    input logic         tck,
    input logic         por_n,
    input logic         dbg_rst_n,
    input logic         instr_dbg,
    input logic         shf_dr,
    input logic         upd_dr,
    input logic         tdo,
    input phase_e       phase,
    input logic         dir,
    input logic [W-1:0] regs_flat
);
    // R2: reset holds the controller in the select phase
    assert_rst_phase_R2: assert property (@(posedge tck) disable iff (!por_n)
        !dbg_rst_n |-> (phase == PH_SELECT));

    // R9: no serial output outside shift-DR
    assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!dbg_rst_n)
        !shf_dr |-> !tdo);

    // R7: losing the instruction returns to select
    assert_noinstr_select_R7: assert property (@(posedge tck) disable iff (!dbg_rst_n)
        !instr_dbg |=> (phase == PH_SELECT));

    // R4: select update advances to data
    assert_sel_to_data_R4: assert property (@(posedge tck) disable iff (!dbg_rst_n)
        (instr_dbg && upd_dr && phase == PH_SELECT) |=> (phase == PH_DATA));

    // R4: data update returns to select
    assert_data_to_sel_R4: assert property (@(posedge tck) disable iff (!dbg_rst_n)
        (instr_dbg && upd_dr && phase == PH_DATA) |=> (phase == PH_SELECT));

    // R6: registers change only at a write-direction data update
    assert_bank_stable_R6: assert property (@(posedge tck) disable iff (!dbg_rst_n)
        !(instr_dbg && upd_dr && phase == PH_DATA && dir) |=> $stable(regs_flat));
endmodule

bind dbg_scan_port dsp_checker #(.W(NUM_REGS*DATA_W)) u_chk (
    .tck       (tck),
    .por_n     (por_n),
    .dbg_rst_n (dbg_rst_n),
    .instr_dbg (instr_dbg),
    .shf_dr    (shf_dr),
    .upd_dr    (upd_dr),
    .tdo       (tdo),
    .phase     (phase_q),
    .dir       (dir_q),
    .regs_flat (regs_flat)
);

// File: tb/tb_dbg_scan_port.sv
`timescale 1ns/1ps
module tb_dbg_scan_port;
    localparam int NREG = 4;

    logic tck = 1'b0;
    logic por_n = 1'b0, tst_comp_en = 1'b0, dbg_lock = 1'b0, instr_dbg = 1'b0;
    logic cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
    logic tdo, dbg_rst_n;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [31:0] model [NREG];

    always #4 tck = ~tck;

    dbg_scan_port dut (
        .tck(tck), .por_n(por_n), .tst_comp_en(tst_comp_en), .dbg_lock(dbg_lock),
        .instr_dbg(instr_dbg), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .tdi(tdi), .tdo(tdo), .dbg_rst_n(dbg_rst_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        return (idx < NREG) ? model[idx] : 32'h0;
    endfunction

    function automatic logic exp_rst(input logic p, input logic c, input logic l);
        return p && c && !l;
    endfunction

    // one DR pass: capture, nbits shifts, update
    task automatic scan(input int nbits, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        @(negedge tck); cap_dr = 1'b1;
        @(negedge tck); cap_dr = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            shf_dr = 1'b1; tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge tck);
        end
        shf_dr = 1'b0; upd_dr = 1'b1;
        @(negedge tck); upd_dr = 1'b0;
    endtask

    task automatic access(input int idx, input bit wr, input logic [31:0] data,
                          input string req);
        logic [31:0] so, exp;
        scan(8, {24'h0, 7'(idx), wr}, so);
        chk(so == 0, "R3", so, 0);
        exp = exp_read(idx);
        scan(32, data, so);
        chk(so == exp, req, so, exp);
        if (wr && idx < NREG) model[idx] = data;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge tck); cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] so;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NREG; i++) model[i] = '0;

        // R1: reset source combinations
        for (int k = 0; k < 8; k++) begin
            por_n = k[0]; tst_comp_en = k[1]; dbg_lock = k[2];
            #1 chk(dbg_rst_n == exp_rst(k[0], k[1], k[2]), "R1", 32'(dbg_rst_n),
                   32'(exp_rst(k[0], k[1], k[2])));
        end
        por_n = 1'b1; tst_comp_en = 1'b1; dbg_lock = 1'b0;
        @(negedge tck); @(negedge tck);
        chk(tdo == 1'b0, "R9", 32'(tdo), 0);
        instr_dbg = 1'b1;

        // R2: reset state reads zero
        for (int i = 0; i < NREG; i++) access(i, 0, 32'hFFFF_FFFF, "R2");

        // R5 write returns old data, R6 read ignores shifted-in data
        access(1, 1, 32'hA5A5_A5A5, "R5");
        access(1, 1, 32'h1234_5678, "R5");
        access(1, 0, 32'hDEAD_BEEF, "R6");
        access(1, 0, 32'h0, "R6");
        access(3, 1, 32'h8000_0001, "R5");

        // R8: unmapped index
        access(100, 1, 32'hCAFE_F00D, "R8");
        access(100, 0, 32'h0, "R8");
        access(127, 1, 32'h5555_AAAA, "R8");
        for (int i = 0; i < NREG; i++) access(i, 0, 32'h0, "R8");

        // R7: lose instruction between the two passes
        access(1, 1, 32'hA5A5_A5A5, "R5");
        scan(8, {24'h0, 7'd2, 1'b1}, so);        // select write of reg 2
        instr_dbg = 1'b0;
        scan(32, 32'h0BAD_0BAD, so);             // ignored pass
        chk(so == 0, "R7", so, 0);
        scan(8, {24'h0, 7'd2, 1'b1}, so);
        chk(so == 0, "R7", so, 0);
        scan(32, 32'h0BAD_0BAD, so);
        chk(so == 0, "R7", so, 0);
        instr_dbg = 1'b1;
        access(1, 0, 32'h0, "R7");               // must be a fresh select pass
        access(2, 0, 32'h0, "R7");

        // R4: random back-to-back accesses
        for (int n = 0; n < 60; n++) begin
            int idx = int'($urandom_range(0, 7));
            bit wr  = 1'($urandom_range(0, 1));
            access(idx, wr, $urandom(), wr ? "R4" : "R6");
        end

        // R2: secured mode pulse clears everything
        @(negedge tck); dbg_lock = 1'b1;
        #1 chk(dbg_rst_n == 1'b0, "R1", 32'(dbg_rst_n), 0);
        @(negedge tck); @(negedge tck); dbg_lock = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        for (int i = 0; i < NREG; i++) access(i, 0, 32'h0, "R2");

        // R2: compliance enable low mid-access
        access(0, 1, 32'h7777_0001, "R5");
        scan(8, {24'h0, 7'd0, 1'b0}, so);
        @(negedge tck); tst_comp_en = 1'b0;
        @(negedge tck); tst_comp_en = 1'b1;
        model[0] = '0;
        access(0, 0, 32'h0, "R2");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule